// File: doc/BRIEF.md
# Host Transfer FIFO with Fill Alarms

This block is a byte-wide first-in first-out store between a disk-bus transfer engine (the device side) and a host DMA unit (the host side). One direction is active at a time. In the transmit direction the host writes bytes and the engine pops them. In the receive direction the engine writes bytes and the host reads them. Every host access is accepted in the cycle it is presented, with no wait states. The engine gets registered full and empty flags, so it can pause the bus transfer instead of overrunning or starving the store.

Three alarms go to the host DMA unit. The refill alarm asks for a burst of writes while the fill level is low. The drain alarm asks for a burst of reads while the fill level is high. Both trip points are held in registers that can be written at run time. The end-of-transfer alarm asks the host to flush whatever bytes remain once the engine reports that the bus transfer has finished.

Top module: `hostq_fifo`

## Requirements
- R1: A write or read presented on a clock edge is accepted on that edge. `level` shows the new count after that edge. A byte popped on that edge appears on `q_rdata` after that edge.
- R2: `level` gives the number of bytes stored, from 0 to DEPTH. `full` is 1 exactly when `level` equals DEPTH, and `empty` is 1 exactly when `level` is 0.
- R3: A write while `full` and a read while `empty` leave the contents and `level` unchanged. Either one sets `err_flag`, which stays set until a cycle with `err_clear` high and no new error.
- R4: `tx_alarm` is 1 while `level` is less than or equal to the refill threshold.
- R5: `rx_alarm` is 1 while `level` is greater than or equal to the drain threshold.
- R6: A cycle with `cfg_we` high loads `cfg_val` into the refill threshold when `cfg_sel` is 0, or into the drain threshold when `cfg_sel` is 1. Both alarms use the new value after that edge. Reset restores TX_THR_RST and RX_THR_RST.
- R7: A `xfer_done` pulse while the count after that edge is nonzero sets `eot_alarm`.
- R8: `eot_alarm` clears on the edge where the count becomes 0, or on a cycle with `eot_clear` high. If `eot_clear` and `xfer_done` arrive in the same cycle, the clear wins.
- R9: With `xfer_dir` = 1, `host_wr` writes and `dev_rd` reads. With `xfer_dir` = 0, `dev_wr` writes and `host_rd` reads. In either direction the other side's strobes are ignored.
- R10: Bytes leave in the order they entered, including across pointer wrap and during a simultaneous write and read.
- R11: Synchronous reset gives `level` 0, `empty` 1, `full` 0, `tx_alarm` 1, `eot_alarm` 0 and `err_flag` 0. `rx_alarm` after reset is 1 only when RX_THR_RST is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_dir | input | 1 | 1: host to device, 0: device to host |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| dev_wr | input | 1 | Engine write strobe |
| dev_wdata | input | 8 | Engine write byte |
| dev_rd | input | 1 | Engine read strobe |
| q_rdata | output | 8 | Last byte popped, registered |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 1 | 0: refill threshold, 1: drain threshold |
| cfg_val | input | $clog2(DEPTH+1) | Threshold value |
| xfer_done | input | 1 | Engine reports end of bus transfer |
| eot_clear | input | 1 | Clears the end-of-transfer alarm |
| err_clear | input | 1 | Clears the sticky error flag |
| level | output | $clog2(DEPTH+1) | Bytes stored |
| full | output | 1 | Store full |
| empty | output | 1 | Store empty |
| tx_alarm | output | 1 | Refill request |
| rx_alarm | output | 1 | Drain request |
| eot_alarm | output | 1 | Residual flush request |
| err_flag | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench builds the block with DEPTH = 16, a refill threshold of 4 and a drain threshold of 12, instead of 64 bytes with 32-byte trip points. With these values it reaches the full boundary, a pointer wrap and both alarm edges in a few dozen cycles. A complete drain then checks byte order across the wrap. Because the refill default is nonzero, the bench can tell after a reset that a reprogrammed threshold of 0 was discarded.

// File: rtl/hostq_pkg.sv
package hostq_pkg;
  typedef enum logic {
    THR_TX = 1'b0,
    THR_RX = 1'b1
  } thr_sel_e;
endpackage

// File: rtl/hostq_store.sv
module hostq_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hostq_level.sv
module hostq_level #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             err_clear,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             full,
  output logic             empty,
  output logic             err
);
  assign push_ok   = push_req & ~full;
  assign pop_ok    = pop_req & ~empty;
  assign count_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
      err    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      count <= count_nxt;
      full  <= (count_nxt == CNT_W'(DEPTH));
      empty <= (count_nxt == '0);
      err   <= (err & ~err_clear) | (push_req & full) | (pop_req & empty);
    end
  end
endmodule

// File: rtl/hostq_alarm.sv
module hostq_alarm
  import hostq_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int TX_THR_RST = 32,
  parameter int RX_THR_RST = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_nxt,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CNT_W-1:0] cfg_val,
  input  logic             xfer_done,
  input  logic             eot_clear,
  output logic [CNT_W-1:0] tx_thr,
  output logic [CNT_W-1:0] rx_thr,
  output logic             tx_alarm,
  output logic             rx_alarm,
  output logic             eot_alarm
);
  logic [CNT_W-1:0] tx_thr_nxt, rx_thr_nxt;
  logic             drained, eot_nxt;
  thr_sel_e         sel;

  assign sel        = thr_sel_e'(cfg_sel);
  assign tx_thr_nxt = (cfg_we && sel == THR_TX) ? cfg_val : tx_thr;
  assign rx_thr_nxt = (cfg_we && sel == THR_RX) ? cfg_val : rx_thr;
  assign drained    = (count_nxt == '0);
  assign eot_nxt    = (eot_alarm | xfer_done) & ~drained & ~eot_clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr    <= CNT_W'(TX_THR_RST);
      rx_thr    <= CNT_W'(RX_THR_RST);
      tx_alarm  <= 1'b1;
      rx_alarm  <= (RX_THR_RST == 0);
      eot_alarm <= 1'b0;
    end else begin
      tx_thr    <= tx_thr_nxt;
      rx_thr    <= rx_thr_nxt;
      tx_alarm  <= (count_nxt <= tx_thr_nxt);
      rx_alarm  <= (count_nxt >= rx_thr_nxt);
      eot_alarm <= eot_nxt;
    end
  end
endmodule

// File: rtl/hostq_fifo.sv
module hostq_fifo #(
  parameter int DEPTH      = 64,
  parameter int TX_THR_RST = 32,
  parameter int RX_THR_RST = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       xfer_dir,
  input  logic                       host_wr,
  input  logic [7:0]                 host_wdata,
  input  logic                       host_rd,
  input  logic                       dev_wr,
  input  logic [7:0]                 dev_wdata,
  input  logic                       dev_rd,
  output logic [7:0]                 q_rdata,
  input  logic                       cfg_we,
  input  logic                       cfg_sel,
  input  logic [$clog2(DEPTH+1)-1:0] cfg_val,
  input  logic                       xfer_done,
  input  logic                       eot_clear,
  input  logic                       err_clear,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       tx_alarm,
  output logic                       rx_alarm,
  output logic                       eot_alarm,
  output logic                       err_flag
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push_req, pop_req, push_ok, pop_ok;
  logic [7:0]       wdata;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count_nxt, tx_thr, rx_thr;

  assign push_req = xfer_dir ? host_wr : dev_wr;
  assign pop_req  = xfer_dir ? dev_rd  : host_rd;
  assign wdata    = xfer_dir ? host_wdata : dev_wdata;

  hostq_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .err_clear(err_clear), .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(level), .count_nxt(count_nxt),
    .full(full), .empty(empty), .err(err_flag)
  );

  hostq_store #(.DEPTH(DEPTH), .DATA_W(8)) u_store (
    .clk(clk), .rst(rst), .we(push_ok), .waddr(wr_ptr), .wdata(wdata),
    .re(pop_ok), .raddr(rd_ptr), .rdata(q_rdata)
  );

  hostq_alarm #(.DEPTH(DEPTH), .TX_THR_RST(TX_THR_RST), .RX_THR_RST(RX_THR_RST)) u_alarm (
    .clk(clk), .rst(rst), .count_nxt(count_nxt), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_val(cfg_val), .xfer_done(xfer_done),
    .eot_clear(eot_clear), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_alarm(tx_alarm), .rx_alarm(rx_alarm), .eot_alarm(eot_alarm)
  );
endmodule

// File: rtl/hostq_fifo_chk.sv
module hostq_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             push_req,
  input logic             pop_req,
  input logic             err_clear,
  input logic             eot_clear,
  input logic [CNT_W-1:0] level,
  input logic [CNT_W-1:0] tx_thr,
  input logic [CNT_W-1:0] rx_thr,
  input logic             full,
  input logic             empty,
  input logic             tx_alarm,
  input logic             rx_alarm,
  input logic             eot_alarm,
  input logic             err_flag
);
  p_level_range_r2: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(DEPTH));
  p_full_flag_r2: assert property (@(posedge clk) disable iff (rst)
    full == (level == CNT_W'(DEPTH)));
  p_empty_flag_r2: assert property (@(posedge clk) disable iff (rst)
    empty == (level == '0));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && push_req && !pop_req) |=> (level == CNT_W'(DEPTH)) && err_flag);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_req && !push_req) |=> (level == '0) && err_flag);
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clear) |=> err_flag);
  p_tx_alarm_r4: assert property (@(posedge clk) disable iff (rst)
    tx_alarm == (level <= tx_thr));
  p_rx_alarm_r5: assert property (@(posedge clk) disable iff (rst)
    rx_alarm == (level >= rx_thr));
  p_eot_needs_data_r8: assert property (@(posedge clk) disable iff (rst)
    eot_alarm |-> !empty);
  p_eot_clear_r8: assert property (@(posedge clk) disable iff (rst)
    eot_clear |=> !eot_alarm);
endmodule

bind hostq_fifo hostq_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
  .err_clear(err_clear), .eot_clear(eot_clear), .level(level),
  .tx_thr(tx_thr), .rx_thr(rx_thr), .full(full), .empty(empty),
  .tx_alarm(tx_alarm), .rx_alarm(rx_alarm), .eot_alarm(eot_alarm),
  .err_flag(err_flag)
);

// File: tb/hostq_fifo_test.sv
module hostq_fifo_test;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic xfer_dir = 1'b1, host_wr = 0, host_rd = 0, dev_wr = 0, dev_rd = 0;
  logic [7:0] host_wdata = 0, dev_wdata = 0, q_rdata;
  logic cfg_we = 0, cfg_sel = 0, xfer_done = 0, eot_clear = 0, err_clear = 0;
  logic [CW-1:0] cfg_val = 0, level;
  logic full, empty, tx_alarm, rx_alarm, eot_alarm, err_flag;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  hostq_fifo #(.DEPTH(DEPTH), .TX_THR_RST(4), .RX_THR_RST(12)) uut (.*);

  // vector: wr, rd, wdata, chk_data, exp_data, exp_level, exp_tx, exp_rx
  localparam logic [25:0] VEC [8] = '{
    {1'b1, 1'b0, 8'hA0, 1'b0, 8'h00, 5'd1, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'hA1, 1'b0, 8'h00, 5'd2, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'hA2, 1'b0, 8'h00, 5'd3, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'hA3, 1'b0, 8'h00, 5'd4, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'hA4, 1'b0, 8'h00, 5'd5, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'hA5, 1'b1, 8'hA0, 5'd5, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b1, 8'hA1, 5'd4, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h00, 1'b1, 8'hA2, 5'd3, 1'b1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one cycle of strobes; outputs are visible on return
  task automatic op(input bit hw, input bit hr, input bit dw, input bit dr, input logic [7:0] d);
    host_wr = hw; host_rd = hr; dev_wr = dw; dev_rd = dr;
    host_wdata = d; dev_wdata = d;
    @(negedge clk);
    host_wr = 0; host_rd = 0; dev_wr = 0; dev_rd = 0;
  endtask

  task automatic cfg(input bit sel, input int val);
    cfg_we = 1; cfg_sel = sel; cfg_val = CW'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] exp_q [$];
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    check("R11 level", int'(level), 0);
    check("R11 empty", int'(empty), 1);
    check("R11 full", int'(full), 0);
    check("R11 tx", int'(tx_alarm), 1);
    check("R11 rx", int'(rx_alarm), 0);
    check("R11 eot/err", int'({eot_alarm, err_flag}), 0);

    // R1 R4 R5 R10: table walk in host-to-device direction
    foreach (VEC[i]) begin
      op(VEC[i][25], 1'b0, 1'b0, VEC[i][24], VEC[i][23:16]);
      check("R1 level", int'(level), int'(VEC[i][6:2]));
      check("R4 tx_alarm", int'(tx_alarm), int'(VEC[i][1]));
      check("R5 rx_alarm", int'(rx_alarm), int'(VEC[i][0]));
      if (VEC[i][15]) check("R10 order", int'(q_rdata), int'(VEC[i][14:7]));
    end

    // R2 R5: fill to full, crossing the drain threshold
    exp_q = '{8'hA3, 8'hA4, 8'hA5};
    for (int i = 0; i < 13; i++) begin
      op(1, 0, 0, 0, 8'h10 + 8'(i));
      exp_q.push_back(8'h10 + 8'(i));
      if (level == 11) check("R5 below drain", int'(rx_alarm), 0);
      if (level == 12) check("R5 at drain", int'(rx_alarm), 1);
    end
    check("R2 level full", int'(level), 16);
    check("R2 full", int'(full), 1);

    // R3: overflow ignored, sticky error
    op(1, 0, 0, 0, 8'hEE);
    check("R3 overflow level", int'(level), 16);
    check("R3 overflow err", int'(err_flag), 1);
    op(0, 0, 0, 0, 8'h00);
    check("R3 err sticky", int'(err_flag), 1);
    err_clear = 1; @(negedge clk); err_clear = 0;
    check("R3 err cleared", int'(err_flag), 0);

    // R10: drain across pointer wrap
    for (int i = 0; i < 16; i++) begin
      op(0, 0, 0, 1, 8'h00);
      check("R10 drain order", int'(q_rdata), int'(exp_q.pop_front()));
    end
    check("R2 empty", int'(empty), 1);

    // R3: underflow
    op(0, 0, 0, 1, 8'h00);
    check("R3 underflow level", int'(level), 0);
    check("R3 underflow err", int'(err_flag), 1);
    err_clear = 1; @(negedge clk); err_clear = 0;

    // R7 R8: end-of-transfer alarm
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    check("R7 done while empty", int'(eot_alarm), 0);
    for (int i = 0; i < 3; i++) op(1, 0, 0, 0, 8'h30 + 8'(i));
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    check("R7 eot set", int'(eot_alarm), 1);
    op(0, 0, 0, 1, 8'h00); op(0, 0, 0, 1, 8'h00);
    check("R8 eot holds", int'(eot_alarm), 1);
    op(0, 0, 0, 1, 8'h00);
    check("R8 eot clears on empty", int'(eot_alarm), 0);
    op(1, 0, 0, 0, 8'h40); op(1, 0, 0, 0, 8'h41);
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    check("R7 eot set again", int'(eot_alarm), 1);
    eot_clear = 1; @(negedge clk); eot_clear = 0;
    check("R8 eot cleared", int'(eot_alarm), 0);
    xfer_done = 1; eot_clear = 1; @(negedge clk); xfer_done = 0; eot_clear = 0;
    check("R8 clear beats set", int'(eot_alarm), 0);
    op(0, 0, 0, 1, 8'h00); op(0, 0, 0, 1, 8'h00);

    // R6: threshold programming
    cfg(1'b0, 0);
    check("R6 tx thr 0 empty", int'(tx_alarm), 1);
    op(1, 0, 0, 0, 8'h50);
    check("R6 tx thr 0 level 1", int'(tx_alarm), 0);
    cfg(1'b1, 1);
    check("R6 rx thr 1", int'(rx_alarm), 1);

    // R11 R6: reset restores defaults
    rst = 1; @(negedge clk); rst = 0;
    check("R11 level after reset", int'(level), 0);
    op(1, 0, 0, 0, 8'h77);
    check("R6 tx default", int'(tx_alarm), 1);
    check("R6 rx default", int'(rx_alarm), 0);

    // R9: device-to-host direction
    xfer_dir = 0;
    op(1, 0, 0, 0, 8'h99);
    check("R9 host write ignored", int'(level), 1);
    op(0, 0, 1, 0, 8'h5A);
    check("R9 dev write", int'(level), 2);
    op(0, 0, 0, 1, 8'h00);
    check("R9 dev read ignored", int'(level), 2);
    op(0, 1, 0, 0, 8'h00);
    check("R9 host read data", int'(q_rdata), 8'h77);
    check("R9 host read level", int'(level), 1);

    finish_run();
  end
endmodule